// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block models a synchronous static RAM whose write data arrives at the same distance behind its command as read data does. Because both latencies match, a bus master can put reads and writes on consecutive clock edges in any mix, with no idle cycle at a read-to-write turn. A strap selects one of two modes. In pipelined mode, read data sits in an output register and write data follows its command by two edges. In flow-through mode, read data is driven straight from the array and write data follows by one edge.

Commands are sampled on the rising clock edge. Three chip selects of mixed polarity, a write strobe and four active-low byte lane enables make up a command. An advance/load input either loads a new address or steps a two-bit burst counter. The counter order is linear or interleaved, set by a second strap. An active-low clock enable freezes every register. An output enable and a sleep input gate the bus drivers asynchronously.

The shared data bus is split into `dq_in`, `dq_out` and `dq_oe`. A read that targets a word whose late write has not yet reached the array gets the pending lanes merged over the stored word.

A small FSM tracks the burst in progress. State `ST_IDLE` means deselected, `ST_READ` means a read burst and `ST_WRITE` means a write burst. Its transitions are:

- Load: advance low while selected moves to `ST_READ` when the write strobe is high and to `ST_WRITE` when it is low.
- Drop: advance low while not selected, or sleep high, moves to `ST_IDLE`.
- Continue: advance high keeps the current state and steps the counter.
- Freeze: clock enable high keeps everything.

Top module: `latewrite_sram`

## Requirements
- R1: A command is accepted only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at a load edge. Any other combination is a deselect: nothing is written and the bus is not driven.
- R2: Pipelined mode (`flow_mode`=0): a read loaded at edge k drives `dq_oe`=1 and the word on `dq_out` after edge k+1, until edge k+2.
- R3: Flow-through mode (`flow_mode`=1): a read loaded at edge k drives its word after edge k itself.
- R4: Pipelined mode: a write loaded at edge k stores the `dq_in` value sampled at edge k+2.
- R5: Flow-through mode: a write loaded at edge k stores the `dq_in` value sampled at edge k+1.
- R6: `byte_we_n[i]`=0 writes bits [9i+8:9i]; lanes whose bit is 1 keep their contents. A write with all four bits at 1 changes no memory.
- R7: `adv`=1 repeats the previous operation at the next burst address. Only address bits [1:0] change, and they wrap after four accesses. With `burst_linear`=1 the n-th address low bits are (base+n) mod 4; with `burst_linear`=0 they are base XOR n. A continue after a deselect stays deselected.
- R8: While `clk_en_n`=1, clock edges are ignored and all pipeline state holds. A pipelined read on the bus stays driven.
- R9: `oe_n`=1 forces `dq_oe`=0 at once. The bus is never driven in a cycle that is not a read data cycle, including write cycles with `oe_n`=0.
- R10: `sleep`=1 forces `dq_oe`=0 at once. Commands sampled while it is high are treated as deselects.
- R11: In pipelined mode, a read loaded one edge after a write to the same address returns the written lanes from that write's data merged with the stored lanes.
- R12: After reset `dq_oe` is 0. Asserting reset during a read drops the bus at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Clock enable, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| byte_we_n | input | NBYTES | Byte lane write enables, active low |
| adv | input | 1 | 1 = advance burst, 0 = load address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| flow_mode | input | 1 | Strap: 1 = flow-through, 0 = pipelined |
| burst_linear | input | 1 | Strap: 1 = linear, 0 = interleaved burst |
| addr | input | ADDR_W | Word address |
| dq_in | input | NBYTES*BYTE_W | Write data from bus |
| dq_out | output | NBYTES*BYTE_W | Read data to bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The bench drives reads and writes on consecutive edges with no gaps. A design with mismatched write latency then stores the wrong bus beat, and the scoreboard sees a wrong word on readback. A read placed one edge after a partial write to the same word catches a missing bypass, which would return stale lanes. Bursts run in both counter orders and wrap past four accesses, so a wrong order or a counter that overflows into bit 2 is caught. Clock-enable stalls are placed between a read and its data and between a write and its data; a design that keeps moving during a stall drops the driven word or samples the wrong data beat. Deselects, sleep and aborted writes all try to write, and each is followed by a readback to show the word is unchanged.

// File: rtl/lwsram_pkg.sv
package lwsram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_state_e;

    // low two address bits of the n-th access of a burst
    function automatic logic [1:0] burst_step(input logic [1:0] base,
                                              input logic [1:0] n,
                                              input logic       linear);
        return linear ? 2'(base + n) : (base ^ n);
    endfunction

endpackage

// File: rtl/lwsram_array.sv
module lwsram_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_mask,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    // one storage column per byte lane
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b]) begin
                lane_mem[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = lane_mem[rd_addr];
    end

endmodule

// File: rtl/lwsram_cmd_fsm.sv
module lwsram_cmd_fsm
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              we_n,
    input  logic [NBYTES-1:0] byte_we_n,
    input  logic              adv,
    input  logic              sleep,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr,
    output logic              s1_valid,
    output logic              s1_wr,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [NBYTES-1:0] s1_mask
);
    burst_state_e      state, nxt_state;
    logic [ADDR_W-1:0] base, nxt_base, cmd_addr;
    logic [1:0]        cnt, nxt_cnt;
    logic              chip_on;

    always_comb begin
        chip_on   = !sel1_n && sel2 && !sel3_n && !sleep;
        nxt_state = state;
        nxt_base  = base;
        nxt_cnt   = cnt;
        cmd_addr  = addr;
        if (sleep) begin
            nxt_state = ST_IDLE;
        end else if (!adv) begin
            nxt_base = addr;
            nxt_cnt  = 2'd0;
            if (!chip_on) begin
                nxt_state = ST_IDLE;
            end else if (we_n) begin
                nxt_state = ST_READ;
            end else begin
                nxt_state = ST_WRITE;
            end
        end else begin
            nxt_cnt  = 2'(cnt + 2'd1);
            cmd_addr = {base[ADDR_W-1:2], burst_step(base[1:0], nxt_cnt, linear)};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            base  <= '0;
            cnt   <= 2'd0;
        end else if (!hold) begin
            state <= nxt_state;
            base  <= nxt_base;
            cnt   <= nxt_cnt;
        end
    end

    // command stage outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_wr    <= 1'b0;
            s1_addr  <= '0;
            s1_mask  <= '0;
        end else if (!hold) begin
            unique case (nxt_state)
                ST_IDLE:  begin s1_valid <= 1'b0; s1_wr <= 1'b0; end
                ST_READ:  begin s1_valid <= 1'b1; s1_wr <= 1'b0; end
                ST_WRITE: begin s1_valid <= 1'b1; s1_wr <= 1'b1; end
                default:  begin s1_valid <= 1'b0; s1_wr <= 1'b0; end
            endcase
            s1_addr <= cmd_addr;
            s1_mask <= ~byte_we_n;
        end
    end

    assert_stall_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(state) && $stable(s1_addr) && $stable(s1_valid)));

    assert_select_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !adv && !sleep && !sel1_n && sel2 && !sel3_n && !we_n) |=> (s1_valid && s1_wr));

    assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !adv && (sel1_n || !sel2 || sel3_n)) |=> !s1_valid);

    assert_burst_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv && !sleep && state != ST_IDLE)
        |=> (s1_addr[1:0] != $past(s1_addr[1:0]) && s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

endmodule

// File: rtl/lwsram_datapath.sv
module lwsram_datapath #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hold,
    input  logic                     flow,
    input  logic                     oe_n,
    input  logic                     sleep,
    input  logic                     s1_valid,
    input  logic                     s1_wr,
    input  logic [ADDR_W-1:0]        s1_addr,
    input  logic [NBYTES-1:0]        s1_mask,
    input  logic [NBYTES*BYTE_W-1:0] dq_in,
    input  logic [NBYTES*BYTE_W-1:0] rd_data,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [NBYTES-1:0]        wr_mask,
    output logic [NBYTES*BYTE_W-1:0] dq_out,
    output logic                     dq_oe
);
    localparam int DW = NBYTES * BYTE_W;

    logic              s2_valid, s2_wr, out_valid;
    logic [ADDR_W-1:0] s2_addr;
    logic [NBYTES-1:0] s2_mask;
    logic [DW-1:0]     out_q, merged;
    logic              s1_rd, s1_wrc, s2_wrc, addr_hit, drive;

    assign s1_rd    = s1_valid && !s1_wr;
    assign s1_wrc   = s1_valid && s1_wr;
    assign s2_wrc   = s2_valid && s2_wr;
    assign addr_hit = s2_wrc && (s2_addr == s1_addr);

    // late write commit: one stage in flow-through, two in pipelined
    assign wr_en   = !hold && (flow ? s1_wrc : s2_wrc);
    assign wr_addr = flow ? s1_addr : s2_addr;
    assign wr_mask = flow ? s1_mask : s2_mask;

    // bypass of the write landing on this same edge
    for (genvar b = 0; b < NBYTES; b++) begin : g_bypass
        assign merged[b*BYTE_W +: BYTE_W] = (addr_hit && s2_mask[b]) ?
            dq_in[b*BYTE_W +: BYTE_W] : rd_data[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid  <= 1'b0;
            s2_wr     <= 1'b0;
            s2_addr   <= '0;
            s2_mask   <= '0;
            out_valid <= 1'b0;
            out_q     <= '0;
        end else if (!hold) begin
            s2_valid  <= s1_valid;
            s2_wr     <= s1_wr;
            s2_addr   <= s1_addr;
            s2_mask   <= s1_mask;
            out_valid <= s1_rd;
            if (s1_rd) begin
                out_q <= merged;
            end
        end
    end

    assign drive  = flow ? s1_rd : out_valid;
    assign dq_oe  = drive && !oe_n && !sleep;
    assign dq_out = flow ? rd_data : out_q;

    assert_quiet_on_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !dq_oe);

    assert_pipe_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow && !hold && s1_valid && !s1_wr) |=> (dq_oe || oe_n || sleep));

endmodule

// File: rtl/latewrite_sram.sv
module latewrite_sram #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en_n,
    input  logic                     sel1_n,
    input  logic                     sel2,
    input  logic                     sel3_n,
    input  logic                     we_n,
    input  logic [NBYTES-1:0]        byte_we_n,
    input  logic                     adv,
    input  logic                     oe_n,
    input  logic                     sleep,
    input  logic                     flow_mode,
    input  logic                     burst_linear,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] dq_in,
    output logic [NBYTES*BYTE_W-1:0] dq_out,
    output logic                     dq_oe
);
    localparam int DW = NBYTES * BYTE_W;

    logic              s1_valid, s1_wr, wr_en;
    logic [ADDR_W-1:0] s1_addr, wr_addr;
    logic [NBYTES-1:0] s1_mask, wr_mask;
    logic [DW-1:0]     rd_data;

    lwsram_cmd_fsm #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (clk_en_n),
        .sel1_n   (sel1_n),
        .sel2     (sel2),
        .sel3_n   (sel3_n),
        .we_n     (we_n),
        .byte_we_n(byte_we_n),
        .adv      (adv),
        .sleep    (sleep),
        .linear   (burst_linear),
        .addr     (addr),
        .s1_valid (s1_valid),
        .s1_wr    (s1_wr),
        .s1_addr  (s1_addr),
        .s1_mask  (s1_mask)
    );

    lwsram_datapath #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (clk_en_n),
        .flow    (flow_mode),
        .oe_n    (oe_n),
        .sleep   (sleep),
        .s1_valid(s1_valid),
        .s1_wr   (s1_wr),
        .s1_addr (s1_addr),
        .s1_mask (s1_mask),
        .dq_in   (dq_in),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_mask (wr_mask),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    lwsram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_mem (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_mask(wr_mask),
        .wr_data(dq_in),
        .rd_addr(s1_addr),
        .rd_data(rd_data)
    );

endmodule

// File: tb/tb_latewrite_sram.sv
module tb_latewrite_sram;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 36;
    localparam int OP_DESEL = 0, OP_READ = 1, OP_WRITE = 2, OP_CONT = 3, OP_STALL = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, clk_en_n = 1'b0, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
    logic we_n = 1'b1, adv = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic flow_mode = 1'b0, burst_linear = 1'b1;
    logic [NB-1:0] byte_we_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    latewrite_sram dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .we_n(we_n), .byte_we_n(byte_we_n), .adv(adv), .oe_n(oe_n),
        .sleep(sleep), .flow_mode(flow_mode), .burst_linear(burst_linear), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        int            when;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [DW-1:0] ref_mem [64];
    logic [DW-1:0] din_ring [16];
    int            tick = 0, checks = 0, errors = 0;
    int            b_op = 0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = 2'd0;

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] mkd(input int run, input int a, input int k);
        return DW'(run * 65536 + a * 256 + k) ^ 36'h5A5A5A5A5;
    endfunction

    // driver: one command per clock, pushes expected reads into the scoreboard
    task automatic drive(input int op, input logic [AW-1:0] a, input logic [NB-1:0] ben,
                         input logic [DW-1:0] d, input string tag);
        int            e;
        int            kind;
        logic [AW-1:0] eff;
        @(negedge clk);
        e = tick + 1;
        clk_en_n = (op == OP_STALL);
        adv = 1'b0; sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        we_n = 1'b1; byte_we_n = ben; addr = a;
        dq_in = din_ring[e % 16];
        kind = 0;
        eff = a;
        case (op)
            OP_DESEL: begin
                we_n = 1'b0; byte_we_n = '0;
                case (a[1:0])
                    2'd0: sel1_n = 1'b1;
                    2'd1: sel2 = 1'b0;
                    default: sel3_n = 1'b1;
                endcase
                b_op = 0;
            end
            OP_READ:  begin b_op = 1; b_base = a; b_cnt = 2'd0; kind = 1; end
            OP_WRITE: begin we_n = 1'b0; b_op = 2; b_base = a; b_cnt = 2'd0; kind = 2; end
            OP_CONT: begin
                adv = 1'b1;
                b_cnt = b_cnt + 2'd1;
                eff = {b_base[AW-1:2], burst_linear ? 2'(b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt)};
                kind = b_op;
            end
            default: begin we_n = 1'b0; byte_we_n = '0; end
        endcase
        if (sleep && op != OP_STALL) begin
            kind = 0;
            b_op = 0;
        end
        if (kind == 1) begin
            sb_q.push_back('{e + (flow_mode ? 0 : 1), ref_mem[eff], tag});
        end else if (kind == 2) begin
            din_ring[(e + (flow_mode ? 1 : 2)) % 16] = d;
            for (int b = 0; b < NB; b++) begin
                if (!ben[b]) ref_mem[eff][b*9 +: 9] = d[b*9 +: 9];
            end
        end
    endtask

    // monitor: compares bus against scoreboard after each edge
    always @(posedge clk) begin
        bit eff_edge;
        eff_edge = rst_n && !clk_en_n;
        if (eff_edge) tick++;
        #2;
        if (eff_edge && sb_q.size() > 0 && sb_q[0].when == tick) begin
            check(dq_oe === 1'b1 && dq_out === sb_q[0].data, sb_q[0].tag, dq_out, sb_q[0].data);
            void'(sb_q.pop_front());
        end else if (eff_edge) begin
            check(dq_oe === 1'b0, "R9 bus idle", {35'd0, dq_oe}, '0);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(OP_DESEL, AW'(i % 3), '1, '0, "");
    endtask

    task automatic do_reset(input logic flow, input logic lin);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(dq_oe === 1'b0, "R12 reset drops bus", {35'd0, dq_oe}, '0);
        sb_q.delete();
        b_op = 0;
        flow_mode = flow;
        burst_linear = lin;
        clk_en_n = 1'b0;
        sleep = 1'b0;
        oe_n = 1'b0;
        repeat (2) @(negedge clk);
        check(dq_oe === 1'b0, "R12 reset state", {35'd0, dq_oe}, '0);
        rst_n = 1'b1;
    endtask

    task automatic run_suite(input int run);
        string tw, tr;
        logic [DW-1:0] held;
        tw = flow_mode ? "R5 write" : "R4 write";
        tr = flow_mode ? "R3 read" : "R2 read";
        // back-to-back writes then reads
        drive(OP_WRITE, 6'd3, 4'h0, mkd(run, 3, 0), tw);
        drive(OP_WRITE, 6'd4, 4'h0, mkd(run, 4, 0), tw);
        drive(OP_READ,  6'd3, '1, '0, tr);
        drive(OP_READ,  6'd4, '1, '0, tr);
        // read/write interleave with no idle edge
        drive(OP_WRITE, 6'd5, 4'h0, mkd(run, 5, 0), tw);
        drive(OP_READ,  6'd3, '1, '0, tr);
        drive(OP_WRITE, 6'd6, 4'h0, mkd(run, 6, 0), tw);
        drive(OP_READ,  6'd5, '1, '0, tr);
        drive(OP_READ,  6'd6, '1, '0, tr);
        // partial write then immediate read: bypass merge
        drive(OP_WRITE, 6'd8, 4'h0, mkd(run, 8, 0), tw);
        idle(2);
        drive(OP_WRITE, 6'd8, 4'b1010, mkd(run, 8, 1), "R6 lane write");
        drive(OP_READ,  6'd8, '1, '0, "R11 bypass merge");
        idle(2);
        drive(OP_READ,  6'd8, '1, '0, "R6 lanes kept");
        // write abort
        drive(OP_WRITE, 6'd9, 4'h0, mkd(run, 9, 0), tw);
        drive(OP_WRITE, 6'd9, 4'hF, mkd(run, 9, 1), "R6 abort");
        idle(2);
        drive(OP_READ,  6'd9, '1, '0, "R6 abort unchanged");
        // deselect patterns try to write, deselect continue stays off
        drive(OP_WRITE, 6'd10, 4'h0, mkd(run, 10, 0), tw);
        idle(3);
        drive(OP_CONT, 6'd0, 4'h0, mkd(run, 10, 7), "R7 desel continue");
        idle(2);
        drive(OP_READ,  6'd10, '1, '0, "R1 deselect no write");
        // burst write of five beats (wraps), then burst read
        drive(OP_WRITE, 6'd17, 4'h0, mkd(run, 17, 0), "R7 burst write");
        for (int k = 1; k < 5; k++) drive(OP_CONT, '0, 4'h0, mkd(run, 17, k), "R7 burst write");
        drive(OP_READ,  6'd17, '1, '0, "R7 burst read");
        for (int k = 1; k < 6; k++) drive(OP_CONT, '0, '1, '0, "R7 burst read");
        idle(3);
        // stall with read data on the bus
        drive(OP_READ, 6'd4, '1, '0, tr);
        if (!flow_mode) drive(OP_DESEL, 6'd0, '1, '0, "");
        held = ref_mem[4];
        drive(OP_STALL, 6'd4, '1, '0, "");
        drive(OP_STALL, 6'd4, '1, '0, "");
        #1;
        check(dq_oe === 1'b1 && dq_out === held, "R8 stall holds read", dq_out, held);
        oe_n = 1'b1;
        #1;
        check(dq_oe === 1'b0, "R9 oe_n async off", {35'd0, dq_oe}, '0);
        oe_n = 1'b0;
        sleep = 1'b1;
        #1;
        check(dq_oe === 1'b0, "R10 sleep async off", {35'd0, dq_oe}, '0);
        sleep = 1'b0;
        #1;
        check(dq_oe === 1'b1, "R8 bus back after async", {35'd0, dq_oe}, 36'd1);
        idle(3);
        // stall between a write and its data edge
        drive(OP_WRITE, 6'd12, 4'h0, mkd(run, 12, 0), "R8 write across stall");
        drive(OP_STALL, 6'd12, '1, '0, "");
        drive(OP_STALL, 6'd12, '1, '0, "");
        idle(3);
        drive(OP_READ, 6'd12, '1, '0, "R8 write across stall");
        idle(2);
        // sleep blocks commands
        sleep = 1'b1;
        drive(OP_WRITE, 6'd12, 4'h0, mkd(run, 12, 9), "R10 sleep write");
        drive(OP_READ,  6'd12, '1, '0, "");
        idle(2);
        sleep = 1'b0;
        idle(1);
        drive(OP_READ, 6'd12, '1, '0, "R10 sleep no write");
        idle(3);
        check(sb_q.size() == 0, "R2 all reads seen", DW'(sb_q.size()), '0);
        // reset in the middle of a read
        drive(OP_READ, 6'd3, '1, '0, tr);
        drive(OP_DESEL, 6'd0, '1, '0, "");
    endtask

    bit done = 1'b0;

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) din_ring[i] = '0;
        do_reset(1'b0, 1'b1);
        run_suite(1);
        do_reset(1'b0, 1'b0);
        run_suite(2);
        do_reset(1'b1, 1'b1);
        run_suite(3);
        do_reset(1'b1, 1'b0);
        run_suite(4);
        do_reset(1'b0, 1'b1);
        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule